// File: doc/BRIEF.md
# Byte-Latched Sleep Timer Compare

This block keeps a free-running sleep counter in a slow clock domain and lets a processor on a fast bus clock read it and program a wake-up point through narrow byte registers. The counter is `8*NUM_BYTES` bits wide, 32 by default, and advances by one on every slow clock edge. Byte lane 0 carries bits [7:0], lane 1 bits [15:8], lane 2 bits [23:16] and lane 3 bits [31:24]. A read of a lane returns count bytes. A write to a lane sets compare bytes.

Reads are made coherent by the order of access. A read of lane 0 returns the live low byte and in the same cycle captures the upper bytes of that count. Reads of the upper lanes then return those captured bytes. Writes run the other way. Upper-lane writes only stage their bytes. A write to lane 0 assembles the full compare word and sends it to the slow domain with a toggle handshake. A `load_done` flag stays low until the slow side acknowledges. While the flag is low, every lane write is dropped. When the counter equals the committed compare value, the slow side raises `wake`.

Software reads lane 0 before the upper lanes, and writes the upper lanes before lane 0.

Top module: `sleep_cmp_timer`

## Requirements
- R1: After reset, `load_done` is 1, `wake` is 0, the counter starts from 0, and the committed compare value is 0.
- R2: The counter increases by exactly one on every slow clock edge outside reset, and wraps modulo 2^(8*NUM_BYTES).
- R3: A read with `bus_sel`=0 returns count bits [7:0] on `bus_rdata` in the same cycle and captures the upper count bytes. A read with `bus_sel`=k (k=1..NUM_BYTES-1) returns captured bits [8k+7:8k].
- R4: The captured upper bytes change only on a read of lane 0. Later upper-lane reads return the value from that lane-0 read, even after the counter has moved on.
- R5: Writes to lanes 1..NUM_BYTES-1 only stage bytes. The committed compare value does not change until lane 0 is written.
- R6: A lane-0 write accepted while `load_done`=1 commits {staged upper bytes, `bus_wdata`} as the new compare word, and `load_done` is 0 in the next bus cycle.
- R7: `load_done` returns to 1 within a bounded number of cycles, once the slow side has taken the new compare word and its acknowledge has crossed back.
- R8: While `load_done` is 0, writes to any lane are ignored. This applies to staged bytes and to the word being transferred.
- R9: `wake` is high for exactly the slow cycle in which the counter equals the committed compare value.
- R10: The value seen through lane reads trails the slow counter by at most two slow cycles. The count crosses domains as a Gray code, so the bus side never sees a torn value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_rd | input | 1 | Read strobe for the selected lane |
| bus_wr | input | 1 | Write strobe for the selected lane |
| bus_sel | input | $clog2(NUM_BYTES) | Byte lane select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected lane |
| load_done | output | 1 | 1 when no compare transfer is pending |
| slow_clk | input | 1 | Slow counter clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| wake | output | 1 | High while count equals committed compare |

## Verification
The bench builds the block with NUM_BYTES=4, so all four lanes, the full 32-bit snapshot and every staging byte are exercised. It uses SYNC_STAGES=3, which stretches the busy window of a transfer. Writes can then land back-to-back inside that window and prove the blocking. The slow clock runs at one fifth of the bus rate. Snapshot coherence is checked across a carry into the second byte. The wake point is checked exactly against an independent count of slow edges.

// File: rtl/sleep_cmp_pkg.sv
package sleep_cmp_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/st_sync.sv
module st_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/st_slow_core.sv
module st_slow_core #(
    parameter int CW     = 32,
    parameter int STAGES = 2
) (
    input  logic          slow_clk,
    input  logic          slow_rst,
    input  logic          req_tog,
    input  logic [CW-1:0] load_word,
    output logic [CW-1:0] gray_q,
    output logic          ack_tog,
    output logic          wake
);
    logic          req_s;
    logic          seen_q;
    logic          take;
    logic [CW-1:0] cnt_q, cnt_nxt, cmp_q, cmp_d;

    st_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
        .clk(slow_clk), .rst(slow_rst), .d(req_tog), .q(req_s)
    );

    assign take    = req_s ^ seen_q;
    assign cmp_d   = take ? load_word : cmp_q;
    assign cnt_nxt = cnt_q + CW'(1);

    always_ff @(posedge slow_clk) begin
        if (slow_rst) begin
            cnt_q  <= '0;
            cmp_q  <= '0;
            seen_q <= 1'b0;
            gray_q <= '0;
            wake   <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            cmp_q  <= cmp_d;
            seen_q <= req_s;
            gray_q <= cnt_nxt ^ (cnt_nxt >> 1);
            wake   <= (cnt_nxt == cmp_d);
        end
    end

    assign ack_tog = seen_q;

    // R2: one step per slow edge
    assert_count_step_R2: assert property (@(posedge slow_clk) disable iff (slow_rst)
        1'b1 |=> cnt_q == $past(cnt_q) + CW'(1));

    // R9: wake only while count and compare agree
    assert_wake_match_R9: assert property (@(posedge slow_clk) disable iff (slow_rst)
        wake |-> cnt_q == cmp_q);

    // R10: the published Gray value moves by one bit at most
    assert_gray_step_R10: assert property (@(posedge slow_clk) disable iff (slow_rst)
        1'b1 |=> $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/st_bus_regs.sv
module st_bus_regs
    import sleep_cmp_pkg::*;
#(
    parameter int NUM_BYTES = 4,
    parameter int STAGES    = 2,
    localparam int CW       = BYTE_W * NUM_BYTES,
    localparam int SEL_W    = $clog2(NUM_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [SEL_W-1:0] bus_sel,
    input  byte_t            bus_wdata,
    output byte_t            bus_rdata,
    output logic             load_done,
    input  logic [CW-1:0]    gray_in,
    input  logic             ack_in,
    output logic             req_tog,
    output logic [CW-1:0]    load_word
);
    logic [CW-1:0] gray_s, bin_c, live_q;
    logic          ack_s;
    logic          busy;
    logic          wr_ok;
    logic          rd_low;
    logic [NUM_BYTES-1:1][BYTE_W-1:0] stage_q;
    logic [NUM_BYTES-1:1][BYTE_W-1:0] snap_q;

    st_sync #(.W(CW), .STAGES(STAGES)) u_cnt_sync (
        .clk(clk), .rst(rst), .d(gray_in), .q(gray_s)
    );
    st_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
        .clk(clk), .rst(rst), .d(ack_in), .q(ack_s)
    );

    // Gray to binary, most significant bit first
    always_comb begin
        bin_c[CW-1] = gray_s[CW-1];
        for (int i = CW - 2; i >= 0; i--) bin_c[i] = bin_c[i+1] ^ gray_s[i];
    end

    always_ff @(posedge clk) begin
        if (rst) live_q <= '0;
        else     live_q <= bin_c;
    end

    assign busy      = req_tog ^ ack_s;
    assign load_done = ~busy;
    assign wr_ok     = bus_wr & ~busy;
    assign rd_low    = bus_rd & (bus_sel == '0);

    for (genvar k = 1; k < NUM_BYTES; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[k] <= '0;
                snap_q[k]  <= '0;
            end else begin
                if (wr_ok && bus_sel == SEL_W'(k)) stage_q[k] <= bus_wdata;
                if (rd_low) snap_q[k] <= live_q[k*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_tog   <= 1'b0;
            load_word <= '0;
        end else if (wr_ok && bus_sel == '0) begin
            req_tog   <= ~req_tog;
            load_word <= {stage_q, bus_wdata};
        end
    end

    always_comb begin
        bus_rdata = live_q[BYTE_W-1:0];
        for (int k = 1; k < NUM_BYTES; k++)
            if (bus_sel == SEL_W'(k)) bus_rdata = snap_q[k];
    end

    // R6: a transfer only starts from a lane-0 write
    assert_busy_start_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_wr && bus_sel == '0));

    // R8: the word in flight is frozen while busy
    assert_word_hold_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(load_word));

    // R4: captured bytes change only on a lane-0 read
    assert_snap_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !rd_low |=> $stable(snap_q));
endmodule

// File: rtl/sleep_cmp_timer.sv
module sleep_cmp_timer
    import sleep_cmp_pkg::*;
#(
    parameter int NUM_BYTES   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = BYTE_W * NUM_BYTES,
    localparam int SEL_W      = $clog2(NUM_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [SEL_W-1:0] bus_sel,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             load_done,
    input  logic             slow_clk,
    input  logic             slow_rst,
    output logic             wake
);
    logic [CW-1:0] gray_w, word_w;
    logic          req_w, ack_w;

    st_bus_regs #(.NUM_BYTES(NUM_BYTES), .STAGES(SYNC_STAGES)) u_bus (
        .clk(clk), .rst(rst),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .load_done(load_done),
        .gray_in(gray_w), .ack_in(ack_w),
        .req_tog(req_w), .load_word(word_w)
    );

    st_slow_core #(.CW(CW), .STAGES(SYNC_STAGES)) u_core (
        .slow_clk(slow_clk), .slow_rst(slow_rst),
        .req_tog(req_w), .load_word(word_w),
        .gray_q(gray_w), .ack_tog(ack_w), .wake(wake)
    );
endmodule

// File: tb/sleep_cmp_timer_test.sv
module sleep_cmp_timer_test;
    logic clk = 0, slow_clk = 0, rst = 1, slow_rst = 1;
    logic rd = 0, wr = 0;
    logic [1:0] sel = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic load_done, wake;

    int total = 0, bad = 0;
    bit finished = 0;

    logic [31:0] exp_cnt;
    int          wake_seen = 0;
    int          wake_wide = 0;
    logic [31:0] wake_at = 0;
    logic        wake_prev = 0;

    sleep_cmp_timer #(.NUM_BYTES(4), .SYNC_STAGES(3)) uut (
        .clk(clk), .rst(rst), .bus_rd(rd), .bus_wr(wr), .bus_sel(sel),
        .bus_wdata(wdata), .bus_rdata(rdata), .load_done(load_done),
        .slow_clk(slow_clk), .slow_rst(slow_rst), .wake(wake)
    );

    always #4  clk = ~clk;
    always #20 slow_clk = ~slow_clk;

    always @(posedge slow_clk) exp_cnt <= slow_rst ? 32'd0 : exp_cnt + 32'd1;

    always @(negedge slow_clk) begin
        if (!slow_rst) begin
            if (wake) begin
                wake_seen++;
                wake_at = exp_cnt;
                if (wake_prev) wake_wide++;
            end
            wake_prev = wake;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic rd_byte(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk); rd = 1; sel = s;
        #1 d = rdata;
        @(negedge clk); rd = 0;
    endtask

    task automatic wr_byte(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); wr = 1; sel = s; wdata = d;
        @(negedge clk); wr = 0;
    endtask

    task automatic read_word(output logic [31:0] w, output logic [31:0] e, input int gap);
        logic [7:0] b0, b1, b2, b3;
        @(negedge clk); rd = 1; sel = 0;
        #1 b0 = rdata; e = exp_cnt;
        @(negedge clk); rd = 0;
        repeat (gap) @(negedge clk);
        rd_byte(1, b1); rd_byte(2, b2); rd_byte(3, b3);
        w = {b3, b2, b1, b0};
    endtask

    task automatic commit(input logic [31:0] v);
        wr_byte(3, v[31:24]); wr_byte(2, v[23:16]); wr_byte(1, v[15:8]); wr_byte(0, v[7:0]);
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (load_done) begin ok = 1; break; end
        end
    endtask

    task automatic wait_past(input logic [31:0] t);
        for (int i = 0; i < 100000; i++) begin
            if (exp_cnt > t + 32'd3) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] w, e;
        chk(load_done == 1'b1, "R1 load_done after reset", {31'd0, load_done}, 32'd1);
        chk(wake == 1'b0, "R1 wake after reset", {31'd0, wake}, 32'd0);
        read_word(w, e, 0);
        chk(w <= e && w + 32'd2 >= e && w < 32'd20, "R1 count starts at zero", w, e);
    endtask

    task automatic t_snapshot();
        logic [31:0] w, e, w2, e2;
        // gap of 1400 bus cycles is 280 slow cycles: crosses a byte-1 carry
        read_word(w, e, 1400);
        chk(w <= e && w + 32'd2 >= e, "R4 upper bytes held from lane-0 read", w, e);
        chk(w <= e && w + 32'd2 >= e, "R10 lag within two slow cycles", w, e);
        read_word(w2, e2, 0);
        chk(w2 > w && w2 <= e2 && w2 + 32'd2 >= e2, "R3 fresh lane-0 read recaptures", w2, e2);
    endtask

    task automatic t_step();
        logic [31:0] w1, e1, w2, e2;
        read_word(w1, e1, 0);
        repeat (500) @(negedge clk);
        read_word(w2, e2, 0);
        chk((w2 - w1) + 32'd2 >= (e2 - e1) && (w2 - w1) <= (e2 - e1) + 32'd2,
            "R2 count advances one per slow edge", w2 - w1, e2 - e1);
    endtask

    task automatic t_commit();
        logic [31:0] w, e, t1;
        bit ok;
        int base;
        read_word(w, e, 0);
        t1 = w + 32'd200;
        commit(t1);
        chk(load_done == 1'b0, "R6 load_done low after lane-0 write", {31'd0, load_done}, 32'd0);
        wait_done(ok);
        chk(ok, "R7 load_done returns", {31'd0, ok}, 32'd1);
        // staging-only writes must not move the compare point
        wr_byte(1, ~t1[15:8]); wr_byte(2, ~t1[23:16]); wr_byte(3, ~t1[31:24]);
        base = wake_seen;
        wait_past(t1);
        chk(wake_seen == base + 1, "R5 one wake at old compare", wake_seen - base, 32'd1);
        chk(wake_at == t1, "R9 wake at compare value", wake_at, t1);
        chk(wake_wide == 0, "R9 wake lasts one slow cycle", wake_wide, 32'd0);
    endtask

    task automatic t_blocked();
        logic [31:0] w, e, t2, t3;
        bit ok;
        int base;
        read_word(w, e, 0);
        t2 = {((w >> 8) + 32'd2) << 8} | 32'h10;
        commit(t2);
        wr_byte(1, ~t2[15:8]);
        wr_byte(0, 8'h55);
        chk(load_done == 1'b0, "R8 still busy during blocked writes", {31'd0, load_done}, 32'd0);
        wait_done(ok);
        chk(ok, "R7 load_done returns after transfer", {31'd0, ok}, 32'd1);
        base = wake_seen;
        wait_past(t2);
        chk(wake_seen == base + 1 && wake_at == t2, "R8 blocked lane-0 write ignored", wake_at, t2);
        t3 = {t2[31:8], 8'hC0};
        wr_byte(0, 8'hC0);
        wait_done(ok);
        base = wake_seen;
        wait_past(t3);
        chk(wake_seen == base + 1 && wake_at == t3, "R8 blocked lane-1 write ignored", wake_at, t3);
        chk(wake_wide == 0, "R9 no stretched wake", wake_wide, 32'd0);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (6) @(posedge slow_clk);
        @(negedge slow_clk); slow_rst = 0;
        @(negedge clk); rst = 0;
        repeat (3) @(negedge clk);
        t_reset();
        t_snapshot();
        t_step();
        t_commit();
        t_blocked();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule